// File: doc/BRIEF.md
# Serial Capture Shifter

This block turns a single serial data pin into a 28-bit parallel word. While the mode select holds the shift-capture code, a divided capture tick is derived from the core clock. On every tick the synchronized pin value is pushed into bit 0 of a shift register, and the older bits move one place toward bit 27. No framing, enable or count is involved. Capture runs for as long as the mode is held, and the bit that falls off bit 27 is dropped without any indication.

A sticky start flag rises with the first captured 1. Its polarity is fixed, so a stream of zeros never sets it. A clear strobe zeroes both the word and the flag. A processor polls the word and the flag at any time without affecting capture. Any other mode code stops the capture tick and freezes the word and the flag.

Top module: `serial_capture_shifter`

## Requirements
- R1: After reset, `word_o` is all zero and `start_o` is 0.
- R2: Capture runs only while `mode_i` equals 2'b10. Codes 2'b00, 2'b01 and 2'b11 stop the tick, reset the divider phase and hold `word_o` and `start_o` unchanged, unless `clr_i` is high.
- R3: In shift-capture mode a capture tick occurs every `div_i`+1 core cycles (1 to 16). The first tick comes on the (`div_i`+1)-th rising edge counted from the first edge at which the mode is active.
- R4: The bit captured at a tick is the value of `sdi_i` sampled two rising edges before that tick, through a two-flop synchronizer.
- R5: On a tick, the new bit enters at bit 0 and each bit k moves to bit k+1.
- R6: Once more than 28 bits have been captured, each further tick discards bit 27, with no overflow output or other indication.
- R7: `start_o` rises with the first tick that captures a 1, never rises through a captured 0, and stays high until a clear.
- R8: `clr_i` high at an edge zeroes `word_o` and `start_o` in any mode, and takes precedence over a capture tick at that same edge.
- R9: `word_o` and `start_o` come straight from registers and can be read in every cycle without disturbing capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Input mode; 2'b10 selects shift-capture |
| div_i | input | 4 | Capture divider: tick period is div_i+1 core cycles |
| clr_i | input | 1 | Clear strobe for word and flag |
| sdi_i | input | 1 | Serial data pin (asynchronous) |
| word_o | output | 28 | Captured shift word, newest bit in bit 0 |
| start_o | output | 1 | Sticky first-one flag |

## Verification
The assertions assume that `mode_i`, `div_i` and `clr_i` are synchronous to `clk`. They also assume that only the synchronizer looks at `sdi_i`. The divider-phase checks apply only while `div_i` is held steady within a capture run. The stimulus changes every input on the falling edge, and it changes `div_i` only between runs or while the tick is idle. A zero-only stretch, a lone 1, long pseudo-random streams longer than 28 bits, mode exits and clears that coincide with ticks cover the corner cases.

// File: rtl/scs_pkg.sv
package scs_pkg;
    localparam int WORD_W  = 28;
    localparam int DIV_W   = 4;
    localparam int SYNC_N  = 2;

    typedef enum logic [1:0] {
        MODE_DIRECT   = 2'b00,
        MODE_PARALLEL = 2'b01,
        MODE_SHIFT    = 2'b10,
        MODE_RSVD     = 2'b11
    } in_mode_e;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              start;
    } shf_state_t;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = pin_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_o = chain_q[STAGES-1];
endmodule

// File: rtl/scs_divider.sv
module scs_divider
    import scs_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic [DW-1:0] div_i,
    output logic          tick_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == div_i);
        tick_o = active_i && at_end;
        if (!active_i)   st_d.cnt = '0;
        else if (at_end) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: an idle divider restarts from phase zero
    a_r2_idle_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> st_q.cnt == '0);

    // R3: with a steady divider the phase never passes the limit
    a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && $stable(div_i) && st_q.cnt <= div_i) |=> st_q.cnt <= div_i);
endmodule

// File: rtl/scs_shifter.sv
module scs_shifter
    import scs_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          clr_i,
    input  logic          bit_i,
    output logic [WW-1:0] word_o,
    output logic          start_o
);
    typedef struct packed {
        logic [WW-1:0] word;
        logic          start;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.word  = '0;
            st_d.start = 1'b0;
        end else if (tick_i) begin
            st_d.word  = {st_q.word[WW-2:0], bit_i};
            st_d.start = st_q.start | bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign start_o = st_q.start;

    // R2: without tick or clear nothing moves
    a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> ($stable(st_q.word) && $stable(st_q.start)));

    // R5: bits move one place toward the top on a tick
    a_r5_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !clr_i) |=> st_q.word[WW-1:1] == $past(st_q.word[WW-2:0]));

    // R7: flag is sticky
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.start && !clr_i) |=> st_q.start);

    // R7: flag only rises with a captured one
    a_r7_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.start) |-> ($past(tick_i) && st_q.word[0]));

    // R8: clear wins over everything
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.word == '0 && !st_q.start));
endmodule

// File: rtl/serial_capture_shifter.sv
module serial_capture_shifter
    import scs_pkg::*;
#(
    parameter int WW = WORD_W,
    parameter int DW = DIV_W,
    parameter int SN = SYNC_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic [DW-1:0] div_i,
    input  logic          clr_i,
    input  logic          sdi_i,
    output logic [WW-1:0] word_o,
    output logic          start_o
);
    logic active;
    logic tick;
    logic pin_s;

    assign active = (mode_i == MODE_SHIFT);

    scs_sync #(.STAGES(SN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (sdi_i),
        .pin_o (pin_s)
    );

    scs_divider #(.DW(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .div_i    (div_i),
        .tick_o   (tick)
    );

    scs_shifter #(.WW(WW)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .clr_i   (clr_i),
        .bit_i   (pin_s),
        .word_o  (word_o),
        .start_o (start_o)
    );

    // R2: no tick outside shift-capture mode
    a_r2_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !tick);
endmodule

// File: tb/serial_capture_shifter_tb.sv
module serial_capture_shifter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [3:0]  div_i = 4'd0;
    logic        clr_i = 1'b0;
    logic        sdi_i = 1'b0;
    logic [27:0] word_o;
    logic        start_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    serial_capture_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .div_i(div_i),
        .clr_i(clr_i), .sdi_i(sdi_i), .word_o(word_o), .start_o(start_o)
    );

    // reference model state
    logic        m_s1 = 0, m_s2 = 0, m_start = 0;
    logic [3:0]  m_cnt = 0;
    logic [27:0] m_word = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [27:0] q_w[$];
    logic        q_s[$];
    string       q_t[$];

    task automatic step(input logic [1:0] m, input logic [3:0] d,
                        input logic c, input logic b, input string tag);
        logic act, tk;
        @(negedge clk);
        mode_i = m; div_i = d; clr_i = c; sdi_i = b;
        act = (m == 2'b10);
        tk  = act && (m_cnt == d);
        if (c) begin
            m_word = '0; m_start = 1'b0;
        end else if (tk) begin
            m_word  = {m_word[26:0], m_s2};
            m_start = m_start | m_s2;
        end
        m_cnt = (!act || tk) ? 4'd0 : m_cnt + 4'd1;
        m_s2 = m_s1;
        m_s1 = b;
        q_w.push_back(m_word);
        q_s.push_back(m_start);
        q_t.push_back(tag);
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_w.size() > 0) begin
                logic [27:0] ew; logic es; string et;
                ew = q_w.pop_front(); es = q_s.pop_front(); et = q_t.pop_front();
                checks++;
                if (word_o !== ew) begin
                    fails++;
                    $display("FAIL %s word actual=%h expected=%h", et, word_o, ew);
                end
                checks++;
                if (start_o !== es) begin
                    fails++;
                    $display("FAIL %s start actual=%b expected=%b", et, start_o, es);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (word_o !== 28'd0 || start_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual=%h/%b expected=0/0", word_o, start_o);
        end
        // R2: direct mode with pin high: nothing captured
        for (int i = 0; i < 6; i++) step(2'b00, 4'd0, 1'b0, 1'b1, "R2");
        // R7: zeros never raise the flag
        for (int i = 0; i < 12; i++) step(2'b10, 4'd0, 1'b0, 1'b0, "R7");
        // R4, R5: a single one walks up from bit 0
        step(2'b10, 4'd0, 1'b0, 1'b1, "R4");
        for (int i = 0; i < 6; i++) step(2'b10, 4'd0, 1'b0, 1'b0, "R5");
        // R6: long stream overflows the 28-bit word
        for (int i = 0; i < 40; i++) step(2'b10, 4'd0, 1'b0, next_bit(), "R6");
        // R3: divided ticks (restart from idle so the phase is clean)
        step(2'b11, 4'd3, 1'b0, 1'b0, "R2");
        for (int i = 0; i < 24; i++) step(2'b10, 4'd3, 1'b0, next_bit(), "R3");
        step(2'b00, 4'd15, 1'b0, 1'b0, "R2");
        for (int i = 0; i < 50; i++) step(2'b10, 4'd15, 1'b0, next_bit(), "R3");
        // R2: parallel mode freezes
        for (int i = 0; i < 8; i++) step(2'b01, 4'd2, 1'b0, next_bit(), "R2");
        // R8: clear while active
        for (int i = 0; i < 7; i++) step(2'b10, 4'd2, 1'b0, 1'b1, "R7");
        step(2'b10, 4'd2, 1'b1, 1'b1, "R8");
        for (int i = 0; i < 10; i++) step(2'b10, 4'd2, 1'b0, next_bit(), "R8");
        // R8: clear while idle
        step(2'b00, 4'd0, 1'b1, 1'b0, "R8");
        // R8: clear beats tick every cycle
        for (int i = 0; i < 5; i++) step(2'b10, 4'd0, 1'b0, 1'b1, "R7");
        for (int i = 0; i < 3; i++) step(2'b10, 4'd0, 1'b1, 1'b1, "R8");
        // R9: continuous reads during capture
        for (int i = 0; i < 20; i++) step(2'b10, 4'd1, 1'b0, next_bit(), "R9");
        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule